// File: doc/BRIEF.md
# Double-Indexed DMA Address Generator

This block produces the byte address sequence for one DMA channel transfer. A transfer (a block) is a number of frames, and each frame is a number of elements. The controlling logic programs a start address, an element size code, an addressing mode, element and frame counts, and two signed strides. It then pulses `start`. The configuration is captured at that moment. The generator presents the address of the first element.

Each `step` pulse consumes the current element and moves the address to the next one. The strides are applied on top of the element size. With negative strides, one engine can walk a frame buffer backwards, mirrored or rotated. Two flags mark the last element of a frame and the last element of the whole block. A readback output holds the address of the element most recently consumed.

Bus transactions, bursting and data packing are handled elsewhere.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset, `busy`, `cur_addr`, `end_frame`, `end_block` and `last_addr` are all zero.
- R2: A `start` pulse captures the configuration. From the next cycle, `busy` is 1, `cur_addr` equals `cfg_start_addr`, and `last_addr` is 0. This also applies while a transfer is running (restart). A `start` and a `step` in the same cycle act as a start only.
- R3: Size code `cfg_esize` selects the element size: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes.
- R4: Mode `cfg_amode`=0 keeps the address fixed on every step.
- R5: Mode 1 adds the element size on every step, including steps that cross a frame boundary.
- R6: In mode 3, a step inside a frame adds size + element index − 1. The element index `cfg_eidx` is signed 16-bit.
- R7: In mode 3, the step after the last element of a frame adds size + frame index − 1. The frame index is the signed 32-bit value {`cfg_fidx_hi`,`cfg_fidx_lo`}, with the high half in bits 31:16.
- R8: Mode 2 adds size + element index − 1 on every step, including steps that cross a frame boundary.
- R9: While `busy`, `end_frame` is 1 exactly when the current element is the last one of its frame. `end_block` is 1 exactly when it is also in the last frame. Counts are 16-bit, and a count of 0 acts as 1.
- R10: A step taken while `end_block` is 1 drops `busy` and leaves `cur_addr` unchanged. While idle, steps do not change `cur_addr` or `last_addr`, and both flags stay at 0.
- R11: Address arithmetic wraps modulo 2^32.
- R12: Each accepted step loads `last_addr` with the `cur_addr` value it consumed.
- R13: Configuration inputs changed while a transfer is running do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture configuration and begin a transfer |
| step | input | 1 | Consume the current element |
| cfg_start_addr | input | 32 | First element address |
| cfg_esize | input | 2 | Element size code |
| cfg_amode | input | 2 | Addressing mode |
| cfg_elem_cnt | input | 16 | Elements per frame |
| cfg_frame_cnt | input | 16 | Frames per block |
| cfg_eidx | input | 16 | Signed element index |
| cfg_fidx_hi | input | 16 | Frame index, upper half |
| cfg_fidx_lo | input | 16 | Frame index, lower half |
| busy | output | 1 | Transfer in progress |
| cur_addr | output | 32 | Address of the current element |
| end_frame | output | 1 | Current element is the last one of its frame |
| end_block | output | 1 | Current element is the last one of the block |
| last_addr | output | 32 | Address of the most recently consumed element |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 16-bit counts and strides, and the indexed modes enabled. All four addressing modes are therefore reachable, and so is wraparound at the top of the 32-bit space. Small element and frame counts (including zero) bring frame and block boundaries within a few cycles. Frame indices whose upper half is non-zero exercise the split programming of the frame stride, and negative indices exercise backward traversal.

// File: rtl/dag_pkg.sv
package dag_pkg;

   typedef enum logic [1:0] {
      AM_FIXED    = 2'd0,
      AM_INC      = 2'd1,
      AM_ELEM_IDX = 2'd2,
      AM_DUAL_IDX = 2'd3
   } amode_e;

   // Size code to bytes: 0 -> 1, 1 -> 2, 2 and 3 -> 4
   function automatic logic [2:0] esize_bytes(input logic [1:0] code);
      case (code)
         2'd0:    esize_bytes = 3'd1;
         2'd1:    esize_bytes = 3'd2;
         default: esize_bytes = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/dag_cfg.sv
module dag_cfg
   import dag_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int CNT_W   = 16,
   parameter int EIDX_W  = 16,
   parameter int FHALF_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [1:0]          in_mode,
   input  logic [1:0]          in_esize,
   input  logic [CNT_W-1:0]    in_elem_cnt,
   input  logic [CNT_W-1:0]    in_frame_cnt,
   input  logic [EIDX_W-1:0]   in_eidx,
   input  logic [FHALF_W-1:0]  in_fidx_hi,
   input  logic [FHALF_W-1:0]  in_fidx_lo,
   output amode_e              mode,
   output logic [2:0]          size,
   output logic [ADDR_W-1:0]   eidx_ext,
   output logic [ADDR_W-1:0]   fidx_ext,
   output logic [CNT_W-1:0]    elem_last,
   output logic [CNT_W-1:0]    frame_last
);
   localparam int FIDX_W = 2 * FHALF_W;

   logic signed [EIDX_W-1:0] eidx_s;
   logic signed [FIDX_W-1:0] fidx_s;
   logic [CNT_W-1:0]         elem_last_d;
   logic [CNT_W-1:0]         frame_last_d;

   assign eidx_s = in_eidx;
   assign fidx_s = {in_fidx_hi, in_fidx_lo};

   // a count of zero behaves as a count of one
   assign elem_last_d  = (in_elem_cnt  == '0) ? '0 : in_elem_cnt  - CNT_W'(1);
   assign frame_last_d = (in_frame_cnt == '0) ? '0 : in_frame_cnt - CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode       <= AM_FIXED;
         size       <= 3'd1;
         eidx_ext   <= '0;
         fidx_ext   <= '0;
         elem_last  <= '0;
         frame_last <= '0;
      end else if (load) begin
         mode       <= amode_e'(in_mode);
         size       <= esize_bytes(in_esize);
         eidx_ext   <= ADDR_W'(eidx_s);
         fidx_ext   <= ADDR_W'(fidx_s);
         elem_last  <= elem_last_d;
         frame_last <= frame_last_d;
      end
   end

endmodule

// File: rtl/dag_pos.sv
module dag_pos #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [CNT_W-1:0] elem_last,
   input  logic [CNT_W-1:0] frame_last,
   output logic             at_frame_end,
   output logic             at_block_end
);
   logic [CNT_W-1:0] elem_q;
   logic [CNT_W-1:0] frame_q;

   assign at_frame_end = (elem_q == elem_last);
   assign at_block_end = at_frame_end && (frame_q == frame_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elem_q  <= '0;
         frame_q <= '0;
      end else if (clr) begin
         elem_q  <= '0;
         frame_q <= '0;
      end else if (adv) begin
         if (at_frame_end) begin
            elem_q  <= '0;
            frame_q <= frame_q + CNT_W'(1);
         end else begin
            elem_q  <= elem_q + CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/dag_stride.sv
module dag_stride
   import dag_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter bit INDEXED_EN = 1'b1
) (
   input  amode_e             mode,
   input  logic [2:0]         size,
   input  logic [ADDR_W-1:0]  eidx_ext,
   input  logic [ADDR_W-1:0]  fidx_ext,
   input  logic               frame_wrap,
   output logic [ADDR_W-1:0]  incr
);
   logic [ADDR_W-1:0] size_ext;
   assign size_ext = ADDR_W'(size);

   generate
      if (INDEXED_EN) begin : g_indexed
         logic [ADDR_W-1:0] idx_sel;
         assign idx_sel = (mode == AM_DUAL_IDX && frame_wrap) ? fidx_ext : eidx_ext;
         always_comb begin
            case (mode)
               AM_FIXED: incr = '0;
               AM_INC:   incr = size_ext;
               default:  incr = size_ext + idx_sel - ADDR_W'(1);
            endcase
         end
      end else begin : g_linear
         assign incr = (mode == AM_FIXED) ? '0 : size_ext;
      end
   endgenerate

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
   import dag_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 16,
   parameter int EIDX_W     = 16,
   parameter int FHALF_W    = 16,
   parameter bit INDEXED_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               step,
   input  logic [ADDR_W-1:0]  cfg_start_addr,
   input  logic [1:0]         cfg_esize,
   input  logic [1:0]         cfg_amode,
   input  logic [CNT_W-1:0]   cfg_elem_cnt,
   input  logic [CNT_W-1:0]   cfg_frame_cnt,
   input  logic [EIDX_W-1:0]  cfg_eidx,
   input  logic [FHALF_W-1:0] cfg_fidx_hi,
   input  logic [FHALF_W-1:0] cfg_fidx_lo,
   output logic               busy,
   output logic [ADDR_W-1:0]  cur_addr,
   output logic               end_frame,
   output logic               end_block,
   output logic [ADDR_W-1:0]  last_addr
);
   localparam int FIDX_W = 2 * FHALF_W;

   generate
      if (FIDX_W > ADDR_W) begin : g_chk_fidx
         $error("frame index wider than the address");
      end
      if (EIDX_W > ADDR_W) begin : g_chk_eidx
         $error("element index wider than the address");
      end
      if (ADDR_W < 8 || CNT_W < 1) begin : g_chk_min
         $error("address or count width too small");
      end
   endgenerate

   amode_e            mode_q;
   logic [2:0]        size_q;
   logic [ADDR_W-1:0] eidx_q;
   logic [ADDR_W-1:0] fidx_q;
   logic [CNT_W-1:0]  elem_last_q;
   logic [CNT_W-1:0]  frame_last_q;
   logic              fr_end;
   logic              blk_end;
   logic [ADDR_W-1:0] incr;
   logic              busy_q;
   logic [ADDR_W-1:0] cur_q;
   logic [ADDR_W-1:0] last_q;
   logic              step_ok;
   logic              adv;

   assign step_ok = step && busy_q && !start;
   assign adv     = step_ok && !blk_end;

   dag_cfg #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .EIDX_W (EIDX_W),
      .FHALF_W(FHALF_W)
   ) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (start),
      .in_mode     (cfg_amode),
      .in_esize    (cfg_esize),
      .in_elem_cnt (cfg_elem_cnt),
      .in_frame_cnt(cfg_frame_cnt),
      .in_eidx     (cfg_eidx),
      .in_fidx_hi  (cfg_fidx_hi),
      .in_fidx_lo  (cfg_fidx_lo),
      .mode        (mode_q),
      .size        (size_q),
      .eidx_ext    (eidx_q),
      .fidx_ext    (fidx_q),
      .elem_last   (elem_last_q),
      .frame_last  (frame_last_q)
   );

   dag_pos #(.CNT_W(CNT_W)) u_pos (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (start),
      .adv         (adv),
      .elem_last   (elem_last_q),
      .frame_last  (frame_last_q),
      .at_frame_end(fr_end),
      .at_block_end(blk_end)
   );

   dag_stride #(
      .ADDR_W    (ADDR_W),
      .INDEXED_EN(INDEXED_EN)
   ) u_stride (
      .mode      (mode_q),
      .size      (size_q),
      .eidx_ext  (eidx_q),
      .fidx_ext  (fidx_q),
      .frame_wrap(fr_end),
      .incr      (incr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cur_q  <= '0;
         last_q <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cur_q  <= cfg_start_addr;
         last_q <= '0;
      end else if (step_ok) begin
         last_q <= cur_q;
         if (blk_end) begin
            busy_q <= 1'b0;
         end else begin
            cur_q  <= cur_q + incr;
         end
      end
   end

   assign busy      = busy_q;
   assign cur_addr  = cur_q;
   assign last_addr = last_q;
   assign end_frame = busy_q && fr_end;
   assign end_block = busy_q && blk_end;

endmodule

// File: rtl/dag_checker.sv
module dag_checker #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              step,
   input logic [ADDR_W-1:0] cfg_start_addr,
   input logic              busy,
   input logic [ADDR_W-1:0] cur_addr,
   input logic              end_frame,
   input logic              end_block,
   input logic [ADDR_W-1:0] last_addr
);

   assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy && cur_addr == $past(cfg_start_addr) && last_addr == '0);

   assert_block_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
      end_block |-> end_frame);

   assert_idle_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !end_frame && !end_block);

   assert_finish_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !start && end_block) |=> !busy);

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(cur_addr) && $stable(last_addr));

   assert_readback_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (step && busy && !start) |=> last_addr == $past(cur_addr));

endmodule

bind dma_addr_gen dag_checker #(.ADDR_W(ADDR_W)) u_dag_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start         (start),
   .step          (step),
   .cfg_start_addr(cfg_start_addr),
   .busy          (busy),
   .cur_addr      (cur_addr),
   .end_frame     (end_frame),
   .end_block     (end_block),
   .last_addr     (last_addr)
);

// File: tb/tb_dma_addr_gen.sv
`timescale 1ns/1ps
module tb_dma_addr_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        step = 1'b0;
   logic [31:0] cfg_start_addr = '0;
   logic [1:0]  cfg_esize = '0;
   logic [1:0]  cfg_amode = '0;
   logic [15:0] cfg_elem_cnt = '0;
   logic [15:0] cfg_frame_cnt = '0;
   logic [15:0] cfg_eidx = '0;
   logic [15:0] cfg_fidx_hi = '0;
   logic [15:0] cfg_fidx_lo = '0;
   logic        busy;
   logic [31:0] cur_addr;
   logic        end_frame;
   logic        end_block;
   logic [31:0] last_addr;

   int total = 0;
   int bad = 0;
   string tag = "R1";

   // reference state
   bit          m_busy = 0;
   logic [31:0] m_addr = '0;
   logic [31:0] m_last = '0;
   int          m_e = 0, m_f = 0, m_en = 1, m_fn = 1;
   int          m_mode = 0, m_size = 1;
   logic [31:0] m_eidx = '0, m_fidx = '0;

   always #2.5 clk = ~clk;

   dma_addr_gen dut (
      .clk(clk), .rst_n(rst_n), .start(start), .step(step),
      .cfg_start_addr(cfg_start_addr), .cfg_esize(cfg_esize), .cfg_amode(cfg_amode),
      .cfg_elem_cnt(cfg_elem_cnt), .cfg_frame_cnt(cfg_frame_cnt), .cfg_eidx(cfg_eidx),
      .cfg_fidx_hi(cfg_fidx_hi), .cfg_fidx_lo(cfg_fidx_lo),
      .busy(busy), .cur_addr(cur_addr), .end_frame(end_frame),
      .end_block(end_block), .last_addr(last_addr)
   );

   task automatic model_edge(input bit st, input bit sp);
      int ie;
      logic [31:0] inc;
      if (st) begin
         m_mode = int'(cfg_amode);
         case (cfg_esize)
            2'd0: m_size = 1;
            2'd1: m_size = 2;
            default: m_size = 4;
         endcase
         ie = $signed(cfg_eidx);
         m_eidx = ie;
         m_fidx = {cfg_fidx_hi, cfg_fidx_lo};
         m_en = (cfg_elem_cnt == 0) ? 1 : int'(cfg_elem_cnt);
         m_fn = (cfg_frame_cnt == 0) ? 1 : int'(cfg_frame_cnt);
         m_busy = 1; m_addr = cfg_start_addr; m_last = '0; m_e = 0; m_f = 0;
      end else if (sp && m_busy) begin
         m_last = m_addr;
         if (m_e == m_en - 1 && m_f == m_fn - 1) begin
            m_busy = 0;
         end else begin
            case (m_mode)
               0: inc = '0;
               1: inc = m_size;
               2: inc = m_size + m_eidx - 1;
               default: inc = m_size + ((m_e == m_en - 1) ? m_fidx : m_eidx) - 1;
            endcase
            m_addr = m_addr + inc;
            if (m_e == m_en - 1) begin m_e = 0; m_f++; end
            else m_e++;
         end
      end
   endtask

   task automatic compare();
      bit ef, eb;
      ef = m_busy && (m_e == m_en - 1);
      eb = ef && (m_f == m_fn - 1);
      total++;
      if (busy !== m_busy || cur_addr !== m_addr || end_frame !== ef ||
          end_block !== eb || last_addr !== m_last) begin
         bad++;
         $display("FAIL %s: busy=%0b addr=%h ef=%0b eb=%0b last=%h expected busy=%0b addr=%h ef=%0b eb=%0b last=%h",
                  tag, busy, cur_addr, end_frame, end_block, last_addr,
                  m_busy, m_addr, ef, eb, m_last);
      end
   endtask

   task automatic cyc(input bit st, input bit sp);
      start = st; step = sp;
      model_edge(st, sp);
      @(posedge clk);
      @(negedge clk);
      start = 0; step = 0;
      compare();
   endtask

   task automatic setup(input logic [31:0] a, input logic [1:0] sz, input logic [1:0] md,
                        input int ec, input int fc, input int ei, input logic [31:0] fi);
      cfg_start_addr = a; cfg_esize = sz; cfg_amode = md;
      cfg_elem_cnt = 16'(ec); cfg_frame_cnt = 16'(fc); cfg_eidx = 16'(ei);
      cfg_fidx_hi = fi[31:16]; cfg_fidx_lo = fi[15:0];
   endtask

   task automatic walk(input int n);
      for (int i = 0; i < n; i++) begin
         cyc(0, 1);
         if (i % 3 == 2) cyc(0, 0);
      end
   endtask

   initial begin
      #(5.0 * 150000);
      bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      tag = "R1"; compare();
      rst_n = 1'b1;
      @(negedge clk); compare();
      tag = "R10"; cyc(0, 1); // step while idle after reset

      // R5 R3: mode 1, 16-bit, 3 x 2
      tag = "R5"; setup(32'h1000, 2'd1, 2'd1, 3, 2, 0, 0);
      cyc(1, 0); walk(7);

      // R4: fixed address
      tag = "R4"; setup(32'h2222_0000, 2'd2, 2'd0, 2, 3, 7, 32'h99);
      cyc(1, 0); walk(7);

      // R6 R7: mirrored rows, negative strides
      tag = "R6"; setup(32'h0000_8000, 2'd2, 2'd3, 4, 3, -7, 32'hFFFF_FFF0);
      cyc(1, 0);
      tag = "R7"; walk(13);

      // R7: frame stride with upper half set
      tag = "R7"; setup(32'h10, 2'd0, 2'd3, 2, 3, 3, 32'h0001_0004);
      cyc(1, 0); walk(7);

      // R8: mode 2 uses element index everywhere
      tag = "R8"; setup(32'h400, 2'd0, 2'd2, 3, 2, 5, 32'h0100_0000);
      cyc(1, 0); walk(7);

      // R11: wrap
      tag = "R11"; setup(32'hFFFF_FFF8, 2'd2, 2'd1, 5, 1, 0, 0);
      cyc(1, 0); walk(6);
      tag = "R11"; setup(32'h4, 2'd1, 2'd3, 3, 1, -9, 0);
      cyc(1, 0); walk(4);

      // R9: zero counts act as one
      tag = "R9"; setup(32'hABC0, 2'd0, 2'd1, 0, 0, 0, 0);
      cyc(1, 0); walk(3);
      tag = "R9"; setup(32'h50, 2'd1, 2'd1, 1, 4, 0, 0);
      cyc(1, 0); walk(5);

      // R3: size code 3 behaves as 4 bytes
      tag = "R3"; setup(32'h300, 2'd3, 2'd1, 4, 1, 0, 0);
      cyc(1, 0); walk(4);

      // R10 R12: steps after completion ignored, readback held
      tag = "R10"; walk(3);
      tag = "R12"; setup(32'h7000, 2'd0, 2'd3, 3, 2, 2, 32'h0000_0010);
      cyc(1, 0); walk(3);

      // R13: configuration changes mid-transfer
      tag = "R13"; setup(32'hC000, 2'd1, 2'd3, 3, 3, 4, 32'h20);
      cyc(1, 0); cyc(0, 1);
      setup(32'h1, 2'd0, 2'd0, 9, 9, -1, 32'hFFFF_0000);
      walk(9);

      // R2: restart while busy, and start with step together
      tag = "R2"; setup(32'hD000, 2'd2, 2'd1, 4, 4, 0, 0);
      cyc(1, 0); walk(3);
      setup(32'hE000, 2'd0, 2'd3, 2, 2, -2, 32'hFFFF_FFFC);
      cyc(1, 1); walk(5);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule